// File: doc/BRIEF.md
# Serial Synthesizer Programming Interface

This block takes a 19-bit control word delivered on a three-wire serial link (a shift clock, a data line and a load-enable strobe) and places it in one of two holding registers. The least significant bit of the word selects the target. One register holds the feedback divide value. The other holds the reference divide value together with three control flags: lock-output enable, reference-prescaler bypass and test select. Both registers drive their contents as parallel buses to the divider and phase/lock detection logic.

The serial wires are sampled in a free-running system clock domain through a synchronizer. Shifting happens on each detected rising edge of the serial clock, and the transfer into a holding register happens on the detected rising edge of the load strobe. Two external conditions shape the outputs. A width-select pin trims the feedback divide bus to 16 bits or leaves all 18 bits. The stored bypass flag trims the reference divide bus to 13 bits or leaves all 15 bits. A battery-save input has no effect on any stored contents.

Top module: `synth_prog_if`

## Requirements
- R1: After reset, every output bus and flag is zero.
- R2: A DATA value is captured on each rising edge of the serial clock. The first bit captured ends up as word bit 18 after 19 clocks, and the last bit captured is word bit 0.
- R3: On a load-strobe rising edge with word bit 0 = 0, word bits 18..1 go to the feedback divide register, with bit 1 as divide bit 0. The reference register and the flags are unchanged.
- R4: On a load-strobe rising edge with word bit 0 = 1, the reference register takes its value from word bits 18..4, with bit 4 as value bit 0. The flags come from word bit 3 (lock-output enable), word bit 2 (prescaler bypass) and word bit 1 (test select). The feedback divide register is unchanged.
- R5: When the width-select input is 1, feedback-bus bits 17..16 read as 0 and bits 15..0 show the stored value. When it is 0, all 18 stored bits are shown. The stored value itself is never altered by this input.
- R6: When the stored bypass flag is 0, reference-bus bits 14..13 read as 0. When it is 1, all 15 stored bits are shown.
- R7: The holding registers change only on a load-strobe rising edge. Shifting without a strobe leaves every output unchanged.
- R8: The battery-save input has no effect. Stored contents are kept while it is low, and loading still works while it is low.
- R9: If more than 19 bits are clocked in before a strobe, only the last 19 bits form the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low power-on reset |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_le_i | input | 1 | Load strobe, rising edge transfers the word |
| wide_sel_i | input | 1 | 1 = 16-bit feedback divide, 0 = 18-bit |
| bsave_n_i | input | 1 | Battery-save input, low = saving |
| n_div_o | output | 18 | Feedback divide value |
| ref_div_o | output | 15 | Reference divide value |
| lock_out_en_o | output | 1 | Lock-output enable flag |
| ref_direct_o | output | 1 | Reference prescaler bypass flag |
| test_sel_o | output | 1 | Test select flag |

## Verification
A mis-steered transfer shows on the bus that should have stayed put, and it shows within the few sampling cycles of synchronizer latency after the strobe edge. A bit-order or off-by-one fault in the shift path scrambles the divide value in a way that is visible on the first strobe. A fault in the width masks shows at once when the width pin or the bypass flag toggles. Words loaded with distinctive, asymmetric patterns let any single misplaced bit be seen.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
    localparam int WORD_W     = 19;
    localparam int N_W        = WORD_W - 1;
    localparam int N_NARROW   = 16;
    localparam int REF_W      = 15;
    localparam int REF_NARROW = 13;
    localparam int REF_LSB    = WORD_W - REF_W;

    typedef struct packed {
        logic [N_W-1:0]   n_val;
        logic [REF_W-1:0] ref_val;
        logic             lock_en;
        logic             bypass;
        logic             test;
    } hold_t;
endpackage

// File: rtl/prog_sync.sv
module prog_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] rise
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
        logic [W-1:0]             prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.stg[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            s_d.stg[i] = s_q.stg[i-1];
        end
        s_d.prev = s_q.stg[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q    = s_q.stg[STAGES-1];
    assign rise = s_q.stg[STAGES-1] & ~s_q.prev;
endmodule

// File: rtl/prog_shift.sv
module prog_shift
    import synth_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (shift_en) sr_d = {sr_q[WORD_W-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign word = sr_q;

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sr_q[0] == $past(bit_in)));                 // R2
    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sr_q[WORD_W-1:1] == $past(sr_q[WORD_W-2:0]))); // R9
endmodule

// File: rtl/prog_hold.sv
module prog_hold
    import synth_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output hold_t             regs
);
    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (load) begin
            if (!word[0]) begin
                h_d.n_val = word[WORD_W-1:1];
            end else begin
                h_d.ref_val = word[WORD_W-1:REF_LSB];
                h_d.lock_en = word[3];
                h_d.bypass  = word[2];
                h_d.test    = word[1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign regs = h_q;

    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(h_q));                                   // R7
    AST_N_KEEPS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !word[0]) |=> ($stable(h_q.ref_val) && $stable(h_q.lock_en)
                                && $stable(h_q.bypass) && $stable(h_q.test))); // R3
    AST_REF_KEEPS_N: assert property (@(posedge clk) disable iff (!rst_n)
        (load && word[0]) |=> $stable(h_q.n_val));                 // R4
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
    import synth_prog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk_i,
    input  logic             ser_data_i,
    input  logic             ser_le_i,
    input  logic             wide_sel_i,
    input  logic             bsave_n_i,
    output logic [N_W-1:0]   n_div_o,
    output logic [REF_W-1:0] ref_div_o,
    output logic             lock_out_en_o,
    output logic             ref_direct_o,
    output logic             test_sel_o
);
    localparam int IDX_CLK  = 0;
    localparam int IDX_DATA = 1;
    localparam int IDX_LE   = 2;

    logic [2:0]        pins, pins_q, pins_rise;
    logic [WORD_W-1:0] word;
    hold_t             regs;

    assign pins = {ser_le_i, ser_data_i, ser_clk_i};

    prog_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pins),
        .q    (pins_q),
        .rise (pins_rise)
    );

    prog_shift u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(pins_rise[IDX_CLK]),
        .bit_in  (pins_q[IDX_DATA]),
        .word    (word)
    );

    prog_hold u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .load (pins_rise[IDX_LE]),
        .word (word),
        .regs (regs)
    );

    always_comb begin
        n_div_o = regs.n_val;
        if (wide_sel_i) n_div_o[N_W-1:N_NARROW] = '0;
        ref_div_o = regs.ref_val;
        if (!regs.bypass) ref_div_o[REF_W-1:REF_NARROW] = '0;
    end

    assign lock_out_en_o = regs.lock_en;
    assign ref_direct_o  = regs.bypass;
    assign test_sel_o    = regs.test;

    AST_SAVE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bsave_n_i && !pins_rise[IDX_LE]) |=> $stable(regs));     // R8
    AST_NARROW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wide_sel_i |-> (n_div_o[N_NARROW-1:0] == regs.n_val[N_NARROW-1:0])); // R5
endmodule

// File: tb/synth_prog_if_test.sv
module synth_prog_if_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic wide_sel = 1'b0, bsave_n = 1'b1;
    logic [17:0] n_div;
    logic [14:0] ref_div;
    logic lock_en, ref_direct, test_sel;
    int checks = 0, failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    synth_prog_if uut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_data_i(ser_data),
        .ser_le_i(ser_le), .wide_sel_i(wide_sel), .bsave_n_i(bsave_n),
        .n_div_o(n_div), .ref_div_o(ref_div), .lock_out_en_o(lock_en),
        .ref_direct_o(ref_direct), .test_sel_o(test_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] bits, input int nb);
        for (int i = nb - 1; i >= 0; i--) begin
            ser_data = bits[i];
            wait_cyc(4);
            ser_clk = 1'b1;
            wait_cyc(4);
            ser_clk = 1'b0;
        end
        wait_cyc(4);
    endtask

    task automatic strobe();
        ser_le = 1'b1;
        wait_cyc(6);
        ser_le = 1'b0;
        wait_cyc(6);
    endtask

    task automatic t_reset();
        chk("R1 n_div", n_div, 0);
        chk("R1 ref_div", ref_div, 0);
        chk("R1 flags", {lock_en, ref_direct, test_sel}, 0);
    endtask

    task automatic t_n_word();
        logic [17:0] v = 18'h2A5C3;
        wide_sel = 1'b0;
        send_bits({13'd0, v, 1'b0}, 19);
        strobe();
        chk("R2 R3 n_div full", n_div, v);
        chk("R3 ref untouched", ref_div, 0);
        wide_sel = 1'b1;
        wait_cyc(1);
        chk("R5 n_div narrow", n_div, {2'b00, v[15:0]});
        wide_sel = 1'b0;
        wait_cyc(1);
        chk("R5 stored kept", n_div, v);
    endtask

    task automatic t_ref_word();
        logic [14:0] r = 15'h5A3C;
        send_bits({13'd0, r, 1'b1, 1'b1, 1'b0, 1'b1}, 19);
        strobe();
        chk("R4 ref_div", ref_div, r);
        chk("R4 flags", {lock_en, ref_direct, test_sel}, 3'b110);
        chk("R4 n untouched", n_div, 18'h2A5C3);
        send_bits({13'd0, r, 1'b0, 1'b0, 1'b1, 1'b1}, 19);
        strobe();
        chk("R6 ref narrow", ref_div, {2'b00, r[12:0]});
        chk("R4 flags b", {lock_en, ref_direct, test_sel}, 3'b001);
    endtask

    task automatic t_no_strobe();
        logic [17:0] v = 18'h11235;
        send_bits({13'd0, v, 1'b0}, 19);
        chk("R7 n held", n_div, 18'h2A5C3);
        chk("R7 ref held", ref_div, 15'h1A3C);
        strobe();
        chk("R7 n after strobe", n_div, v);
    endtask

    task automatic t_overlong();
        logic [17:0] v = 18'h30F0F;
        send_bits({9'd0, 4'b1011, v, 1'b0}, 23);
        strobe();
        chk("R9 last 19 bits", n_div, v);
    endtask

    task automatic t_bsave();
        logic [17:0] v = 18'h0BEEF;
        bsave_n = 1'b0;
        wait_cyc(20);
        chk("R8 n kept", n_div, 18'h30F0F);
        chk("R8 ref kept", ref_div, 15'h1A3C);
        send_bits({13'd0, v, 1'b0}, 19);
        strobe();
        chk("R8 load in save", n_div, v);
        bsave_n = 1'b1;
        wait_cyc(4);
        chk("R8 after exit", n_div, v);
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        t_reset();
        t_n_word();
        t_ref_word();
        t_no_strobe();
        t_overlong();
        t_bsave();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule